// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block holds the results of in-flight instructions between the moment they finish executing and the moment they become architectural. Issue logic claims one slot at the tail for each instruction, in program order. The slot number comes back at once and serves as the rename tag that later consumers wait on. Execution units report results by tag in any order. Each result is stored and its slot is marked done. Only the oldest slot, at the head, may update the register file or send a store to memory, and only once it is done. Slots retire one per cycle.

Speculation is undone in two ways. A resolved mispredicted branch discards every slot allocated after it. The tail then sits just past the branch in the same cycle. A fault attached to a result stays dormant until its slot reaches the head. At that point the block raises an exception, writes nothing, and empties itself. Issue logic may also look up any slot by tag to fetch a finished value.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready` is 1, `alloc_tag` is 0, and `cmt_reg_we`, `cmt_store_we` and `cmt_exc` are all 0.
- R2: Accepted allocations receive consecutive tags, wrapping modulo DEPTH. With DEPTH live slots, `alloc_ready` is 0 and a request is dropped: it creates no slot and produces no later commit.
- R3: A completion writes the value and done state into the tagged slot. From the next cycle on, a lookup of that tag gives `lk_ready`=1 and the value. A slot that is live but not yet done gives `lk_ready`=0.
- R4: Results are accepted out of order. No architectural write appears while the head slot is not done, even if younger slots are done.
- R5: Commit depends on the slot kind given at allocation. Kind 0 (register) drives `cmt_reg_we` with `cmt_dest` and `cmt_value`. Kind 1 (store) drives `cmt_store_we` with `cmt_value`. Kind 2 (branch) retires with neither write. The two write strobes are never high together.
- R6: A flush with `flush_tag` discards all slots younger than that tag. The next tag handed out is `flush_tag`+1 modulo DEPTH. Discarded slots never commit, and `alloc_ready` is 0 in the flush cycle.
- R7: A completion with `cpl_fault`=1 raises `cmt_exc` only when that slot is at the head and done. That cycle has no architectural write. Afterwards the buffer is empty and younger slots never commit.
- R8: At most one slot retires per cycle, strictly in allocation order. A done head slot's commit outputs appear in the cycle after its completion is clocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request a slot for an issued instruction |
| alloc_kind | input | 2 | Slot kind: 0 register, 1 store, 2 branch |
| alloc_dest | input | AW | Destination architectural register |
| alloc_ready | output | 1 | A request is accepted this cycle |
| alloc_tag | output | IW | Tag given to a request accepted this cycle |
| cpl_valid | input | 1 | Result report from an execution unit |
| cpl_tag | input | IW | Slot that the result belongs to |
| cpl_value | input | DW | Result value or store data |
| cpl_fault | input | 1 | The instruction faulted |
| flush_valid | input | 1 | A branch resolved as mispredicted |
| flush_tag | input | IW | Tag of the mispredicted branch |
| lk_tag | input | IW | Slot to look up for an operand |
| lk_ready | output | 1 | The looked-up slot holds a finished value |
| lk_value | output | DW | Value of the looked-up slot |
| cmt_reg_we | output | 1 | Register-file write at commit |
| cmt_store_we | output | 1 | Store release at commit |
| cmt_dest | output | AW | Destination register of the committing slot |
| cmt_value | output | DW | Value of the committing slot |
| cmt_exc | output | 1 | Precise exception raised by the head slot |

## Verification
The hardest state to reach is one where younger slots have finished and sit behind an older slot that is not done. A flush or a fault must then cut through that mixture without letting any discarded result reach the architectural outputs. The bench builds this state on purpose. It completes younger slots first. It then flushes at a branch in the middle of the window while an allocation request is held high in the same cycle. In the fault case, it reports a faulting result ahead of its older neighbour. A monitor counts every architectural write, so a squashed slot that commits shows up as an extra write.

// File: rtl/spec_rob_pkg.sv
package spec_rob_pkg;

    typedef enum logic [1:0] {
        KIND_REG    = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_BRANCH = 2'd2,
        KIND_RSVD   = 2'd3
    } rob_kind_e;

endpackage

// File: rtl/spec_rob_ptrs.sv
module spec_rob_ptrs #(
    parameter  int DEPTH = 8,
    localparam int IW    = $clog2(DEPTH),
    localparam int PW    = IW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_fire,
    input  logic             retire_fire,
    input  logic             exc_fire,
    input  logic             flush_valid,
    input  logic [IW-1:0]    flush_tag,
    output logic [PW-1:0]    head_ptr,
    output logic [PW-1:0]    tail_ptr,
    output logic             full,
    output logic             empty,
    output logic [DEPTH-1:0] squash_mask
);

    typedef struct packed {
        logic [PW-1:0] head;
        logic [PW-1:0] tail;
    } ptr_t;

    ptr_t          st_d, st_q;
    logic [PW-1:0] count;
    logic [IW-1:0] head_idx;
    logic [IW-1:0] br_dist;

    always_comb begin
        count    = st_q.tail - st_q.head;
        head_idx = st_q.head[IW-1:0];
        // distance of the branch from the head, modulo DEPTH
        br_dist  = flush_tag - head_idx;
        st_d     = st_q;
        if (retire_fire) begin
            st_d.head = st_q.head + PW'(1);
        end
        if (exc_fire) begin
            st_d.tail = st_d.head;
        end else if (flush_valid) begin
            st_d.tail = st_q.head + PW'(br_dist) + PW'(1);
        end else if (alloc_fire) begin
            st_d.tail = st_q.tail + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // an entry is younger than the branch when its age exceeds the branch age
    for (genvar i = 0; i < DEPTH; i++) begin : g_age
        logic [IW-1:0] age;
        assign age            = IW'(i) - head_idx;
        assign squash_mask[i] = exc_fire || (flush_valid && (age > br_dist));
    end

    assign head_ptr = st_q.head;
    assign tail_ptr = st_q.tail;
    assign full     = (count == PW'(DEPTH));
    assign empty    = (count == '0);

endmodule

// File: rtl/spec_rob_store.sv
module spec_rob_store
    import spec_rob_pkg::*;
#(
    parameter  int DEPTH = 8,
    parameter  int AW    = 5,
    parameter  int DW    = 32,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_fire,
    input  logic [IW-1:0]    alloc_idx,
    input  rob_kind_e        alloc_kind,
    input  logic [AW-1:0]    alloc_dest,
    input  logic             cpl_valid,
    input  logic [IW-1:0]    cpl_tag,
    input  logic [DW-1:0]    cpl_value,
    input  logic             cpl_fault,
    input  logic             retire_fire,
    input  logic [IW-1:0]    head_idx,
    input  logic [DEPTH-1:0] squash_mask,
    input  logic [IW-1:0]    lk_tag,
    output logic             hd_valid,
    output logic             hd_ready,
    output logic             hd_fault,
    output rob_kind_e        hd_kind,
    output logic [AW-1:0]    hd_dest,
    output logic [DW-1:0]    hd_value,
    output logic             lk_ready,
    output logic [DW-1:0]    lk_value
);

    typedef struct packed {
        logic          valid;
        logic          ready;
        logic          fault;
        rob_kind_e     kind;
        logic [AW-1:0] dest;
        logic [DW-1:0] value;
    } ent_t;

    ent_t ent_d [DEPTH];
    ent_t ent_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ent_d[i] = ent_q[i];
            if (cpl_valid && (cpl_tag == IW'(i)) && ent_q[i].valid) begin
                ent_d[i].ready = 1'b1;
                ent_d[i].value = cpl_value;
                ent_d[i].fault = cpl_fault;
            end
            if (retire_fire && (head_idx == IW'(i))) begin
                ent_d[i].valid = 1'b0;
                ent_d[i].ready = 1'b0;
            end
            if (alloc_fire && (alloc_idx == IW'(i))) begin
                ent_d[i].valid = 1'b1;
                ent_d[i].ready = 1'b0;
                ent_d[i].fault = 1'b0;
                ent_d[i].kind  = alloc_kind;
                ent_d[i].dest  = alloc_dest;
                ent_d[i].value = '0;
            end
            if (squash_mask[i]) begin
                ent_d[i].valid = 1'b0;
                ent_d[i].ready = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= ent_d[i];
            end
        end
    end

    assign hd_valid = ent_q[head_idx].valid;
    assign hd_ready = ent_q[head_idx].ready;
    assign hd_fault = ent_q[head_idx].fault;
    assign hd_kind  = ent_q[head_idx].kind;
    assign hd_dest  = ent_q[head_idx].dest;
    assign hd_value = ent_q[head_idx].value;
    assign lk_ready = ent_q[lk_tag].valid && ent_q[lk_tag].ready;
    assign lk_value = ent_q[lk_tag].value;

endmodule

// File: rtl/spec_rob.sv
module spec_rob
    import spec_rob_pkg::*;
#(
    parameter  int DEPTH = 8,
    parameter  int AW    = 5,
    parameter  int DW    = 32,
    localparam int IW    = $clog2(DEPTH),
    localparam int PW    = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    input  logic [1:0]    alloc_kind,
    input  logic [AW-1:0] alloc_dest,
    output logic          alloc_ready,
    output logic [IW-1:0] alloc_tag,
    input  logic          cpl_valid,
    input  logic [IW-1:0] cpl_tag,
    input  logic [DW-1:0] cpl_value,
    input  logic          cpl_fault,
    input  logic          flush_valid,
    input  logic [IW-1:0] flush_tag,
    input  logic [IW-1:0] lk_tag,
    output logic          lk_ready,
    output logic [DW-1:0] lk_value,
    output logic          cmt_reg_we,
    output logic          cmt_store_we,
    output logic [AW-1:0] cmt_dest,
    output logic [DW-1:0] cmt_value,
    output logic          cmt_exc
);

    logic [PW-1:0]    head_q;
    logic [PW-1:0]    tail_q;
    logic             full;
    logic             empty;
    logic [DEPTH-1:0] squash_mask;
    logic             alloc_fire;
    logic             retire_fire;
    logic             exc_fire;
    logic             hd_valid;
    logic             hd_ready;
    logic             hd_fault;
    rob_kind_e        hd_kind;
    logic [AW-1:0]    hd_dest;
    logic [DW-1:0]    hd_value;

    // the head retires once its result is in; a fault turns retirement into an exception
    assign retire_fire = !empty && hd_valid && hd_ready;
    assign exc_fire    = retire_fire && hd_fault;
    assign alloc_ready = !full && !flush_valid && !exc_fire;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign alloc_tag   = tail_q[IW-1:0];

    spec_rob_ptrs #(
        .DEPTH(DEPTH)
    ) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_fire (alloc_fire),
        .retire_fire(retire_fire),
        .exc_fire   (exc_fire),
        .flush_valid(flush_valid),
        .flush_tag  (flush_tag),
        .head_ptr   (head_q),
        .tail_ptr   (tail_q),
        .full       (full),
        .empty      (empty),
        .squash_mask(squash_mask)
    );

    spec_rob_store #(
        .DEPTH(DEPTH),
        .AW   (AW),
        .DW   (DW)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_fire (alloc_fire),
        .alloc_idx  (tail_q[IW-1:0]),
        .alloc_kind (rob_kind_e'(alloc_kind)),
        .alloc_dest (alloc_dest),
        .cpl_valid  (cpl_valid),
        .cpl_tag    (cpl_tag),
        .cpl_value  (cpl_value),
        .cpl_fault  (cpl_fault),
        .retire_fire(retire_fire),
        .head_idx   (head_q[IW-1:0]),
        .squash_mask(squash_mask),
        .lk_tag     (lk_tag),
        .hd_valid   (hd_valid),
        .hd_ready   (hd_ready),
        .hd_fault   (hd_fault),
        .hd_kind    (hd_kind),
        .hd_dest    (hd_dest),
        .hd_value   (hd_value),
        .lk_ready   (lk_ready),
        .lk_value   (lk_value)
    );

    assign cmt_reg_we   = retire_fire && !hd_fault && (hd_kind == KIND_REG);
    assign cmt_store_we = retire_fire && !hd_fault && (hd_kind == KIND_STORE);
    assign cmt_exc      = exc_fire;
    assign cmt_dest     = hd_dest;
    assign cmt_value    = hd_value;

endmodule

// File: rtl/spec_rob_chk.sv
module spec_rob_chk #(
    parameter  int DEPTH = 8,
    localparam int IW    = $clog2(DEPTH),
    localparam int PW    = IW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          alloc_ready,
    input logic          flush_valid,
    input logic [IW-1:0] flush_tag,
    input logic          cmt_reg_we,
    input logic          cmt_store_we,
    input logic          cmt_exc,
    input logic [PW-1:0] head_ptr,
    input logic [PW-1:0] tail_ptr
);

    logic [PW-1:0] occ;
    assign occ = tail_ptr - head_ptr;

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= PW'(DEPTH)); // R2
    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == PW'(DEPTH)) |-> !alloc_ready); // R2
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmt_reg_we && cmt_store_we)); // R5
    AST_FLUSH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && !cmt_exc) |=> (tail_ptr[IW-1:0] == IW'($past(flush_tag) + 1'b1))); // R6
    AST_FLUSH_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> !alloc_ready); // R6
    AST_EXC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_exc |-> !(cmt_reg_we || cmt_store_we)); // R7
    AST_EXC_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_exc |=> (tail_ptr == head_ptr)); // R7
    AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (head_ptr != $past(head_ptr)) |-> (head_ptr == PW'($past(head_ptr) + 1'b1))); // R8
    AST_WRITE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_reg_we || cmt_store_we) |=> (head_ptr == PW'($past(head_ptr) + 1'b1))); // R4

endmodule

bind spec_rob spec_rob_chk #(
    .DEPTH(DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_ready (alloc_ready),
    .flush_valid (flush_valid),
    .flush_tag   (flush_tag),
    .cmt_reg_we  (cmt_reg_we),
    .cmt_store_we(cmt_store_we),
    .cmt_exc     (cmt_exc),
    .head_ptr    (head_q),
    .tail_ptr    (tail_q)
);

// File: tb/spec_rob_bench.sv
`timescale 1ns/1ps
module spec_rob_bench;

    localparam int DEPTH = 8;
    localparam int IW    = 3;

    // {exp_store, exp_reg, kind[1:0], dest[4:0], value[31:0]}
    localparam int NV = 6;
    localparam logic [40:0] VEC [NV] = '{
        {1'b0, 1'b1, 2'd0, 5'd3,  32'h1111_0003},
        {1'b1, 1'b0, 2'd1, 5'd0,  32'h2222_0000},
        {1'b0, 1'b0, 2'd2, 5'd0,  32'h0000_00B0},
        {1'b0, 1'b1, 2'd0, 5'd9,  32'h3333_0009},
        {1'b1, 1'b0, 2'd1, 5'd0,  32'h4444_0004},
        {1'b0, 1'b1, 2'd0, 5'd31, 32'h5555_001F}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_valid = 1'b0;
    logic [1:0]    alloc_kind = '0;
    logic [4:0]    alloc_dest = '0;
    logic          alloc_ready;
    logic [IW-1:0] alloc_tag;
    logic          cpl_valid = 1'b0;
    logic [IW-1:0] cpl_tag = '0;
    logic [31:0]   cpl_value = '0;
    logic          cpl_fault = 1'b0;
    logic          flush_valid = 1'b0;
    logic [IW-1:0] flush_tag = '0;
    logic [IW-1:0] lk_tag = '0;
    logic          lk_ready;
    logic [31:0]   lk_value;
    logic          cmt_reg_we;
    logic          cmt_store_we;
    logic [4:0]    cmt_dest;
    logic [31:0]   cmt_value;
    logic          cmt_exc;

    int n_tests = 0;
    int n_fail  = 0;

    // commit monitor
    logic        mon_en = 1'b0;
    int          mon_reg = 0;
    int          mon_st  = 0;
    int          mon_exc = 0;
    logic [31:0] mon_vals [16];

    always #2.5 clk = ~clk;

    spec_rob u_spec_rob (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_value(cpl_value), .cpl_fault(cpl_fault),
        .flush_valid(flush_valid), .flush_tag(flush_tag),
        .lk_tag(lk_tag), .lk_ready(lk_ready), .lk_value(lk_value),
        .cmt_reg_we(cmt_reg_we), .cmt_store_we(cmt_store_we),
        .cmt_dest(cmt_dest), .cmt_value(cmt_value), .cmt_exc(cmt_exc)
    );

    always @(negedge clk) begin
        if (mon_en) begin
            if (cmt_reg_we) begin
                if (mon_reg < 16) mon_vals[mon_reg] = cmt_value;
                mon_reg++;
            end
            if (cmt_store_we) mon_st++;
            if (cmt_exc) mon_exc++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic mon_clear();
        mon_reg = 0;
        mon_st  = 0;
        mon_exc = 0;
    endtask

    task automatic do_alloc(input logic [1:0] k, input logic [4:0] d, output logic [IW-1:0] t);
        alloc_valid = 1'b1;
        alloc_kind  = k;
        alloc_dest  = d;
        #1 t = alloc_tag;
        @(negedge clk);
        alloc_valid = 1'b0;
    endtask

    task automatic do_cpl(input logic [IW-1:0] t, input logic [31:0] v, input logic f);
        cpl_valid = 1'b1;
        cpl_tag   = t;
        cpl_value = v;
        cpl_fault = f;
        @(negedge clk);
        cpl_valid = 1'b0;
        cpl_fault = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [IW-1:0] t;
        logic [IW-1:0] tags [8];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 alloc_ready", 32'(alloc_ready), 32'd1);
        check("R1 alloc_tag", 32'(alloc_tag), 32'd0);
        check("R1 strobes", {29'd0, cmt_reg_we, cmt_store_we, cmt_exc}, 32'd0);

        // table: allocate every row, complete out of order, drain in order
        for (int r = 0; r < NV; r++) begin
            do_alloc(VEC[r][38:37], VEC[r][36:32], t);
            check("R2 consecutive tag", 32'(t), 32'(r));
        end
        for (int r = NV - 1; r >= 1; r--) begin
            do_cpl(IW'(r), VEC[r][31:0], 1'b0);
            check("R4 no write before head done", {30'd0, cmt_reg_we, cmt_store_we}, 32'd0);
        end
        lk_tag = 3'd3;
        #1 check("R3 lookup done ready", 32'(lk_ready), 32'd1);
        check("R3 lookup value", lk_value, VEC[3][31:0]);
        lk_tag = 3'd0;
        #1 check("R3 lookup pending", 32'(lk_ready), 32'd0);
        do_cpl(3'd0, VEC[0][31:0], 1'b0);
        for (int r = 0; r < NV; r++) begin
            check("R5 reg strobe", 32'(cmt_reg_we), 32'(VEC[r][39]));
            check("R5 store strobe", 32'(cmt_store_we), 32'(VEC[r][40]));
            if (VEC[r][39] || VEC[r][40]) check("R8 commit value order", cmt_value, VEC[r][31:0]);
            if (VEC[r][39]) check("R5 commit dest", 32'(cmt_dest), 32'(VEC[r][36:32]));
            @(negedge clk);
        end
        check("R8 drained", {30'd0, cmt_reg_we, cmt_store_we}, 32'd0);

        // R2: fill to DEPTH, wrap tags, drop the extra request
        for (int i = 0; i < DEPTH; i++) begin
            do_alloc(2'd0, 5'(i + 1), tags[i]);
        end
        check("R2 first tag after table", 32'(tags[0]), 32'd6);
        check("R2 wrapped last tag", 32'(tags[DEPTH-1]), 32'd5);
        check("R2 full stalls", 32'(alloc_ready), 32'd0);
        alloc_valid = 1'b1;
        @(negedge clk);
        alloc_valid = 1'b0;
        mon_clear();
        mon_en = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            do_cpl(tags[i], 32'(100 + i), 1'b0);
        end
        repeat (4) @(negedge clk);
        mon_en = 1'b0;
        check("R2 dropped request made no commit", 32'(mon_reg), 32'(DEPTH));
        for (int i = 0; i < DEPTH; i++) begin
            check("R8 in-order retire", mon_vals[i], 32'(100 + i));
        end

        // R6: flush at a branch with younger finished slots behind it
        mon_clear();
        mon_en = 1'b1;
        do_alloc(2'd0, 5'd4, tags[0]);  // A
        do_alloc(2'd2, 5'd0, tags[1]);  // B branch
        do_alloc(2'd0, 5'd5, tags[2]);  // C younger
        do_alloc(2'd1, 5'd0, tags[3]);  // D younger store
        do_cpl(tags[2], 32'hDEAD_000C, 1'b0);
        do_cpl(tags[3], 32'hDEAD_000D, 1'b0);
        flush_valid = 1'b1;
        flush_tag   = tags[1];
        alloc_valid = 1'b1;
        alloc_kind  = 2'd0;
        #1 check("R6 alloc blocked in flush cycle", 32'(alloc_ready), 32'd0);
        @(negedge clk);
        flush_valid = 1'b0;
        alloc_valid = 1'b0;
        check("R6 tail after branch", 32'(alloc_tag), 32'(IW'(tags[1] + 1)));
        do_cpl(tags[0], 32'h0000_AAAA, 1'b0);
        do_cpl(tags[1], 32'h0, 1'b0);
        do_alloc(2'd0, 5'd6, t);
        do_cpl(t, 32'h0000_EEEE, 1'b0);
        repeat (3) @(negedge clk);
        mon_en = 1'b0;
        check("R6 squashed slots never commit", 32'(mon_reg), 32'd2);
        check("R6 squashed store never released", 32'(mon_st), 32'd0);
        check("R6 survivor value", mon_vals[0], 32'h0000_AAAA);
        check("R6 new slot value", mon_vals[1], 32'h0000_EEEE);

        // R7: fault behind an unfinished older slot
        mon_clear();
        mon_en = 1'b1;
        do_alloc(2'd0, 5'd7, tags[0]);  // F
        do_alloc(2'd0, 5'd8, tags[1]);  // G faulting
        do_alloc(2'd0, 5'd9, tags[2]);  // H
        do_cpl(tags[1], 32'hBAD0_0000, 1'b1);
        do_cpl(tags[2], 32'h0000_0303, 1'b0);
        check("R7 no exception before head", 32'(cmt_exc), 32'd0);
        do_cpl(tags[0], 32'h0000_0101, 1'b0);
        check("R7 older slot commits first", 32'(cmt_reg_we), 32'd1);
        @(negedge clk);
        check("R7 exception at head", 32'(cmt_exc), 32'd1);
        check("R7 no write with exception", {30'd0, cmt_reg_we, cmt_store_we}, 32'd0);
        @(negedge clk);
        repeat (3) @(negedge clk);
        mon_en = 1'b0;
        check("R7 one write only", 32'(mon_reg), 32'd1);
        check("R7 one exception", 32'(mon_exc), 32'd1);
        check("R7 emptied", 32'(alloc_tag), 32'(IW'(tags[1] + 1)));
        check("R7 ready after exception", 32'(alloc_ready), 32'd1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule